// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is the final destination of a trace stream. It accepts 32-bit trace words from an upstream trace source over a valid/ready handshake. It holds each word in a one-entry stage and then writes it into an on-chip SRAM that is addressed as a ring. A write pointer walks the ring in steps of 4 bytes. When the pointer passes the last word it returns to 0 and sets a sticky wrap flag. If the stop-on-wrap policy is selected, capture stops by itself at that point, so the oldest part of the trace is kept.

Software controls the block through a small register window. It can hold the block in reset with the active bit and can start or stop capture with the enable bit. When capture is halted it reads the trace back by loading a read pointer and then reading a data register repeatedly. Each data read returns the word at the read pointer and advances the pointer by 4. After a wrap, the trace is read in two ranges: from the write pointer up to the limit, then from 0 up to the write pointer. Clearing enable drains the stage into the SRAM. The empty bit reports when nothing is left in flight.

Register indices on `csr_idx`: 0 control, 1 limit, 2 write pointer, 3 read pointer, 4 data. Register reads return on `csr_rdata` with `csr_rvalid` high in the cycle after `csr_rd`.

Top module: `trace_ram_sink`

## Requirements
- R1: After reset the control register reads 0x108. The fields are: bit 0 active = 0, bit 1 enable = 0, bit 2 stop-on-wrap = 0, bit 3 empty = 1, bit 8 SRAM-present = 1, bits 10:9 capture mode = 0. The limit register reads DEPTH*4-4 (0xFC with default parameters).
- R2: `in_ready` is low unless both active and enable are 1. A control write sets enable only if active was already 1 before the write. While active is 0, enable, stop-on-wrap, wrap flag and both pointers are held at 0.
- R3: Each accepted input word is written to the SRAM at the write pointer. The pointer then advances by 4, and after the word at the limit address it returns to 0. The write-pointer register shows the byte address in bits [AW+1:2].
- R4: Writing the word at the limit address sets the wrap flag (bit 0 of the write-pointer register). The flag stays set until software writes the write-pointer register.
- R5: With stop-on-wrap set, enable clears by itself once the limit word is written. `in_ready` is low from the cycle in which the limit word is staged. No later word is stored, so the word at address 0 is preserved.
- R6: A write to the write-pointer register loads the pointer from bits [AW+1:2] and the wrap flag from bit 0.
- R7: The read pointer accepts any aligned byte address from 0 to the limit. A data-register read returns the word at the read pointer in the next cycle, then advances the pointer by 4. After the limit, the pointer returns to 0.
- R8: Empty (control bit 3) reads 0 while a word is held in the stage. Clearing enable still lets the staged word reach the SRAM, after which empty reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Trace word offered |
| in_ready | output | 1 | Trace word accepted when high with in_valid |
| in_data | input | 32 | Trace word |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_idx | input | 3 | Register index |
| csr_wdata | input | 32 | Register write data |
| csr_rvalid | output | 1 | Read response valid, one cycle after csr_rd |
| csr_rdata | output | 32 | Read response data |

## Verification
A write pointer that is wrong by even one step shows up when the pointer register is next read. It also appears as a shifted word in the readback sequence, one cycle after the data read. A missed wrap or a stop that fails to take effect shows in the next cycle: `in_ready` stays high, or the preserved word at address 0 is overwritten and later read back as a newer value. A stuck stage entry leaves the empty bit at 0 on every later control read.

// File: rtl/trs_pkg.sv
package trs_pkg;
    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_LIMIT = 3'd1,
        REG_WPTR  = 3'd2,
        REG_RPTR  = 3'd3,
        REG_DATA  = 3'd4
    } trs_reg_e;

    localparam int CTRL_ACTIVE = 0;
    localparam int CTRL_ENABLE = 1;
    localparam int CTRL_STOP   = 2;
    localparam int CTRL_EMPTY  = 3;
    localparam int CTRL_HASRAM = 8;
endpackage

// File: rtl/trs_stage.sv
module trs_stage #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          drain,
    output logic          valid,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } stage_t;

    stage_t q, d;

    always_comb begin
        d = q;
        if (drain) d.valid = 1'b0;
        if (load) begin
            d.valid = 1'b1;
            d.data  = load_data;
        end
        if (clr) d.valid = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = q.valid;
    assign data  = q.data;
endmodule

// File: rtl/trs_store.sv
module trs_store #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/trace_ram_sink.sv
module trace_ram_sink #(
    parameter int DEPTH = 64,
    localparam int DW   = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          csr_wr,
    input  logic          csr_rd,
    input  logic [2:0]    csr_idx,
    input  logic [DW-1:0] csr_wdata,
    output logic          csr_rvalid,
    output logic [DW-1:0] csr_rdata
);
    import trs_pkg::*;

    localparam logic [AW-1:0] LAST      = AW'(DEPTH - 1);
    localparam logic [DW-1:0] LIMIT_VAL = DW'(DEPTH * 4 - 4);

    typedef struct packed {
        logic          active;
        logic          enable;
        logic          stop;
        logic          wrap;
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic          rsp_valid;
        logic          rsp_mem;
        logic [DW-1:0] rsp_data;
    } state_t;

    state_t q, d;

    logic          stg_valid;
    logic [DW-1:0] stg_data;
    logic          accept;
    logic          commit;
    logic          mem_re;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] ctrl_word;
    trs_reg_e      idx;

    assign idx      = trs_reg_e'(csr_idx);
    assign in_ready = q.active && q.enable && !(q.stop && stg_valid && q.wp == LAST);
    assign accept   = in_valid && in_ready;
    assign commit   = stg_valid && q.active;
    assign mem_re   = csr_rd && idx == REG_DATA;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_ACTIVE] = q.active;
        ctrl_word[CTRL_ENABLE] = q.enable;
        ctrl_word[CTRL_STOP]   = q.stop;
        ctrl_word[CTRL_EMPTY]  = !stg_valid;
        ctrl_word[CTRL_HASRAM] = 1'b1;
    end

    always_comb begin
        d = q;
        d.rsp_valid = 1'b0;
        d.rsp_mem   = 1'b0;

        if (commit) begin
            d.wp = q.wp + 1'b1;
            if (q.wp == LAST) begin
                d.wrap = 1'b1;
                if (q.stop) d.enable = 1'b0;
            end
        end

        if (csr_rd) begin
            d.rsp_valid = 1'b1;
            unique case (idx)
                REG_CTRL:  d.rsp_data = ctrl_word;
                REG_LIMIT: d.rsp_data = LIMIT_VAL;
                REG_WPTR:  d.rsp_data = DW'({q.wp, 1'b0, q.wrap});
                REG_RPTR:  d.rsp_data = DW'({q.rp, 2'b00});
                REG_DATA: begin
                    d.rsp_mem = 1'b1;
                    d.rp      = q.rp + 1'b1;
                end
                default:   d.rsp_data = '0;
            endcase
        end

        if (csr_wr) begin
            unique case (idx)
                REG_CTRL: begin
                    d.active = csr_wdata[CTRL_ACTIVE];
                    d.enable = q.active && csr_wdata[CTRL_ACTIVE] && csr_wdata[CTRL_ENABLE];
                    d.stop   = csr_wdata[CTRL_STOP];
                end
                REG_WPTR: begin
                    d.wp   = csr_wdata[AW+1:2];
                    d.wrap = csr_wdata[0];
                end
                REG_RPTR: d.rp = csr_wdata[AW+1:2];
                default: ;
            endcase
        end

        if (!q.active) begin
            d.enable = 1'b0;
            d.stop   = 1'b0;
            d.wrap   = 1'b0;
            d.wp     = '0;
            d.rp     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    trs_stage #(.DW(DW)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!q.active),
        .load      (accept),
        .load_data (in_data),
        .drain     (commit),
        .valid     (stg_valid),
        .data      (stg_data)
    );

    trs_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (commit),
        .waddr (q.wp),
        .wdata (stg_data),
        .re    (mem_re),
        .raddr (q.rp),
        .rdata (mem_rdata)
    );

    assign csr_rvalid = q.rsp_valid;
    assign csr_rdata  = q.rsp_mem ? mem_rdata : q.rsp_data;
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          active,
    input logic          enable,
    input logic          stop,
    input logic          wrap,
    input logic [AW-1:0] wp,
    input logic [AW-1:0] rp,
    input logic          stg_valid,
    input logic          in_ready,
    input logic          csr_wr,
    input logic          csr_rd,
    input logic [2:0]    csr_idx
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    a_r2_ready_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (active && enable));

    a_r2_enable_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> active);

    a_r3_wp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_valid && active && !csr_wr) |=> wp == AW'($past(wp) + 1'b1));

    a_r3_wp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stg_valid && active && !csr_wr) |=> $stable(wp));

    a_r4_wrap_set: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_valid && active && wp == LAST && !csr_wr) |=> wrap);

    a_r5_stop_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_valid && active && stop && wp == LAST && !csr_wr) |=> !enable);

    a_r7_rp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && csr_idx == 3'd4 && active && !csr_wr) |=> rp == AW'($past(rp) + 1'b1));
endmodule

bind trace_ram_sink trs_checker #(.DEPTH(DEPTH)) u_trs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (q.active),
    .enable    (q.enable),
    .stop      (q.stop),
    .wrap      (q.wrap),
    .wp        (q.wp),
    .rp        (q.rp),
    .stg_valid (stg_valid),
    .in_ready  (in_ready),
    .csr_wr    (csr_wr),
    .csr_rd    (csr_rd),
    .csr_idx   (csr_idx)
);

// File: tb/trace_ram_sink_bench.sv
`timescale 1ns/1ps
module trace_ram_sink_bench;
    localparam int DEPTH = 64;
    localparam logic [31:0] LIM = 32'(DEPTH * 4 - 4);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        csr_wr = 1'b0;
    logic        csr_rd = 1'b0;
    logic [2:0]  csr_idx = '0;
    logic [31:0] csr_wdata = '0;
    logic        csr_rvalid;
    logic [31:0] csr_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    trace_ram_sink #(.DEPTH(DEPTH)) u_trace_ram_sink (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_idx(csr_idx), .csr_wdata(csr_wdata),
        .csr_rvalid(csr_rvalid), .csr_rdata(csr_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (csr_rvalid) begin
            if (exp_q.size() == 0) chk("scoreboard-extra", csr_rdata, 32'hx);
            else chk(tag_q.pop_front(), csr_rdata, exp_q.pop_front());
        end
    end

    task automatic csr_write(input logic [2:0] idx, input logic [31:0] v);
        csr_wr = 1'b1; csr_idx = idx; csr_wdata = v;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [2:0] idx, input logic [31:0] exp, input string tag);
        csr_rd = 1'b1; csr_idx = idx;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        csr_rd = 1'b0;
    endtask

    task automatic send(input logic [31:0] w);
        in_valid = 1'b1; in_data = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state and identity
        csr_read(3'd0, 32'h108, "R1 ctrl reset");
        csr_read(3'd1, LIM, "R1 limit");
        chk("R2 ready low in reset", in_ready, 1'b0);

        // R2 enable refused while inactive
        csr_write(3'd0, 32'h3);
        csr_read(3'd0, 32'h109, "R2 enable needs prior active");
        chk("R2 ready low when not enabled", in_ready, 1'b0);
        csr_write(3'd0, 32'h3);
        csr_read(3'd0, 32'h10B, "R2 enabled");
        chk("R2 ready high when enabled", in_ready, 1'b1);

        // R3 capture; R8 empty while staged
        for (int i = 0; i < 5; i++) send(32'hA000_0000 + 32'(i));
        csr_read(3'd0, 32'h103, "R8 empty low while staged");
        csr_read(3'd2, 32'd20, "R3 wp after five words");

        // R8 disable right after accept still flushes
        send(32'hB0B0_B0B0);
        csr_write(3'd0, 32'h1);
        chk("R2 ready low after disable", in_ready, 1'b0);
        csr_read(3'd0, 32'h109, "R8 empty after flush");
        csr_read(3'd2, 32'd24, "R3 wp includes flushed word");

        // R7 readback with auto increment
        csr_write(3'd3, 32'd0);
        for (int i = 0; i < 5; i++) csr_read(3'd4, 32'hA000_0000 + 32'(i), "R7 readback");
        csr_read(3'd4, 32'hB0B0_B0B0, "R8 flushed word in RAM");
        csr_read(3'd3, 32'd24, "R7 rp advanced");

        // R3/R4 wrap without stop
        csr_write(3'd0, 32'h3);
        csr_write(3'd2, LIM - 32'd4);
        for (int i = 0; i < 4; i++) send(32'hC000_0000 + 32'(i));
        @(negedge clk);
        csr_read(3'd2, 32'h9, "R4 wrap flag and wp past start");
        csr_write(3'd3, LIM - 32'd4);
        for (int i = 0; i < 4; i++) csr_read(3'd4, 32'hC000_0000 + 32'(i), "R7 rp wraps at limit");

        // R6 write pointer load
        csr_write(3'd2, 32'h11);
        csr_read(3'd2, 32'h11, "R6 wp and wrap load");
        csr_write(3'd2, 32'h0);
        csr_read(3'd2, 32'h0, "R6 wp write zero");

        // R5 stop on wrap
        csr_write(3'd2, LIM - 32'd4);
        csr_write(3'd0, 32'h7);
        send(32'hD000_0000);
        chk("R5 ready before limit staged", in_ready, 1'b1);
        send(32'hD000_0001);
        chk("R5 ready low with limit staged", in_ready, 1'b0);
        send(32'hD000_0002);
        chk("R5 ready low after stop", in_ready, 1'b0);
        csr_read(3'd0, 32'h10D, "R5 enable self-cleared");
        csr_read(3'd2, 32'h1, "R5 wp at zero with wrap");
        csr_write(3'd3, 32'd0);
        csr_read(3'd4, 32'hC000_0002, "R5 word at start preserved");
        csr_write(3'd3, LIM);
        csr_read(3'd4, 32'hD000_0001, "R5 limit word");
        csr_write(3'd3, LIM - 32'd4);
        csr_read(3'd4, 32'hD000_0000, "R5 word before limit");

        // R2 deactivate clears state
        csr_write(3'd0, 32'h0);
        csr_read(3'd0, 32'h108, "R2 inactive ctrl");
        csr_read(3'd2, 32'h0, "R2 inactive wp cleared");
        chk("R2 ready low inactive", in_ready, 1'b0);

        repeat (4) @(negedge clk);
        chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
        summary();
    end
endmodule